// File: doc/BRIEF.md
# Strobe-Framed PCM Serial Port Pair

This block is the serial front end of a voice processor. It has two PCM ports, each framed by its own active-high enable strobe. The line-side port and the acoustic-side port share one externally supplied bit clock, and its rate may vary. The rising edge of the line strobe marks the start of every frame. The acoustic strobe must follow within a fixed window.

The bit clock, the strobes and the serial inputs are brought into the core clock domain through synchronizers. The block counts how many bit-clock falling edges each strobe stays high for, and from that it works out the word size of the port:

- 8 falls means an 8-bit companded sample.
- 16 falls means a 16-bit two's complement sample.

The first legal strobe fixes the size of its port for good. Any later strobe that disagrees with it is rejected and flagged.

The bit clock must stay high and low for at least four core clock periods each. Strobes and serial input bits must change on the bit-clock rising edge.

Top module: `pcmif_ssi`

## Requirements
- R1: After reset, both serial output enables are low, both receive valid pulses are low, neither port reports a locked width, and all three error flags are clear.
- R2: A port's serial output enable is high exactly while its strobe is high, as seen through the synchronizer delay. While the enable is low, the output is treated as high impedance.
- R3: A port's width locks on its first strobe that stays high for exactly 8 or exactly 16 bit-clock falls. The wide indication is 1 for 16 falls and 0 for 8 falls. A port never reports a valid word while unlocked.
- R4: Input bits are sampled on bit-clock falls, most significant bit first. When an accepted strobe ends, the port gives a single one-cycle valid pulse. The word holds all 16 bits for a wide port; for a narrow port, bits 7:0 hold the sample and bits 15:8 are zero.
- R5: The transmit word is captured when the strobe rises. Its first bit appears at once, and each following bit appears on a bit-clock rise while the strobe stays high, most significant bit first. A port locked wide sends bits 15:0. A port that is narrow or not yet locked sends bits 7:0 and then zeros.
- R6: The two ports detect and lock their widths independently, so one port can run wide while the other runs narrow.
- R7: On a locked port, a strobe of the other legal length raises that port's format error flag, produces no valid pulse, and leaves the locked width unchanged.
- R8: A strobe whose length is neither 8 nor 16 falls raises that port's format error flag and produces no valid pulse. Before lock, such a strobe does not lock the port.
- R9: A window counter starts on each rising edge of the line strobe. The timeout flag is set if no acoustic strobe rises within WINDOW_CLKS core clock cycles of that edge.
- R10: The format error flags and the timeout flag stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, which also times the window |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | External serial bit clock |
| line_ena | input | 1 | Line-side enable strobe; its rise is the frame boundary |
| line_sdi | input | 1 | Line-side serial data in |
| line_sdo | output | 1 | Line-side serial data out |
| line_sdo_oe | output | 1 | Line-side output enable (low means high impedance) |
| line_tx_word | input | 16 | Line-side word to transmit |
| line_rx_word | output | 16 | Line-side received word |
| line_rx_valid | output | 1 | One-cycle pulse when a line word is accepted |
| line_locked | output | 1 | Line port width has been fixed |
| line_wide | output | 1 | Line port width is 16 bits |
| line_fmt_err | output | 1 | Sticky line-side strobe length error |
| acou_ena | input | 1 | Acoustic-side enable strobe |
| acou_sdi | input | 1 | Acoustic-side serial data in |
| acou_sdo | output | 1 | Acoustic-side serial data out |
| acou_sdo_oe | output | 1 | Acoustic-side output enable |
| acou_tx_word | input | 16 | Acoustic-side word to transmit |
| acou_rx_word | output | 16 | Acoustic-side received word |
| acou_rx_valid | output | 1 | One-cycle pulse when an acoustic word is accepted |
| acou_locked | output | 1 | Acoustic port width has been fixed |
| acou_wide | output | 1 | Acoustic port width is 16 bits |
| acou_fmt_err | output | 1 | Sticky acoustic-side strobe length error |
| window_timeout | output | 1 | Sticky flag: acoustic strobe missed its window |

## Verification
The hardest states to reach are the ones that depend on history: a port that is already locked receiving a strobe of the other legal length, and a frame whose acoustic strobe never arrives.

The bench reaches the first by generating strobes one bit clock at a time, with any length chosen per port. After a run of legal frames it sends a 16-fall strobe to a port locked narrow, and strobes of 12 and 5 falls. A reduced window parameter lets a single frame with no acoustic strobe, followed by a long idle stretch, run past the window in a few thousand cycles.

Two separate resets then lock the ports in opposite width combinations. Across the sweeps, every bit position is exercised in both directions.

// File: rtl/pcmif_pkg.sv
package pcmif_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned CNT_W  = 5;

  typedef enum logic [1:0] {LEN_BAD, LEN_NARROW, LEN_WIDE} len_class_e;

  // Sort a counted strobe length into narrow, wide or illegal.
  function automatic len_class_e classify_len(input logic [CNT_W-1:0] n);
    if (n == CNT_W'(8))       return LEN_NARROW;
    else if (n == CNT_W'(16)) return LEN_WIDE;
    else                      return LEN_BAD;
  endfunction

  // A received narrow sample is zero-extended into the low byte.
  function automatic logic [WORD_W-1:0] rx_align(input logic [WORD_W-1:0] sh, input logic wide);
    return wide ? sh : {8'h00, sh[7:0]};
  endfunction

  // A narrow transmit sample is moved to the top so it leaves first.
  function automatic logic [WORD_W-1:0] tx_align(input logic [WORD_W-1:0] w, input logic wide);
    return wide ? w : {w[7:0], 8'h00};
  endfunction
endpackage

// File: rtl/pcmif_sync.sv
module pcmif_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else             chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pcmif_port.sv
module pcmif_port
  import pcmif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_rise,
  input  logic              bclk_fall,
  input  logic              ena_s,
  input  logic              din_s,
  input  logic [WORD_W-1:0] tx_word,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              locked,
  output logic              wide,
  output logic              fmt_err,
  output logic              strobe_start,
  output logic              strobe_end
);
  logic              ena_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] rx_sh;
  logic [WORD_W-1:0] tx_sh;
  len_class_e        cls;
  logic              accept;
  logic              reject;

  assign strobe_start = ena_s & ~ena_d;
  assign strobe_end   = ~ena_s & ena_d;
  assign cls          = classify_len(bit_cnt);
  assign accept       = strobe_end && (cls != LEN_BAD) &&
                        (!locked || (wide == (cls == LEN_WIDE)));
  assign reject       = strobe_end && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_d    <= 1'b0;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
      locked   <= 1'b0;
      wide     <= 1'b0;
      fmt_err  <= 1'b0;
    end else begin
      ena_d    <= ena_s;
      rx_valid <= accept;
      if (strobe_start) begin
        bit_cnt <= '0;
        tx_sh   <= tx_align(tx_word, locked & wide);
      end else begin
        if (bclk_fall && ena_s) begin
          rx_sh <= {rx_sh[WORD_W-2:0], din_s};
          if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
        end
        if (bclk_rise && ena_s) tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
      end
      if (accept) begin
        rx_word <= rx_align(rx_sh, cls == LEN_WIDE);
        if (!locked) begin
          locked <= 1'b1;
          wide   <= (cls == LEN_WIDE);
        end
      end
      if (reject) fmt_err <= 1'b1;
    end
  end

  assign sdo    = tx_sh[WORD_W-1];
  assign sdo_oe = ena_s;
endmodule

// File: rtl/pcmif_window.sv
module pcmif_window #(
  parameter int unsigned WINDOW_CLKS = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic second_start,
  output logic timeout
);
  localparam int unsigned CW = $clog2(WINDOW_CLKS + 1);

  logic          armed;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      cnt     <= '0;
      timeout <= 1'b0;
    end else if (frame_start) begin
      armed <= !second_start;
      cnt   <= '0;
    end else if (armed) begin
      if (second_start) begin
        armed <= 1'b0;
      end else if (cnt == CW'(WINDOW_CLKS - 1)) begin
        armed   <= 1'b0;
        timeout <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcmif_ssi.sv
module pcmif_ssi
  import pcmif_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WINDOW_CLKS = 25000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk,
  input  logic        line_ena,
  input  logic        line_sdi,
  output logic        line_sdo,
  output logic        line_sdo_oe,
  input  logic [15:0] line_tx_word,
  output logic [15:0] line_rx_word,
  output logic        line_rx_valid,
  output logic        line_locked,
  output logic        line_wide,
  output logic        line_fmt_err,
  input  logic        acou_ena,
  input  logic        acou_sdi,
  output logic        acou_sdo,
  output logic        acou_sdo_oe,
  input  logic [15:0] acou_tx_word,
  output logic [15:0] acou_rx_word,
  output logic        acou_rx_valid,
  output logic        acou_locked,
  output logic        acou_wide,
  output logic        acou_fmt_err,
  output logic        window_timeout
);
  localparam int unsigned NPORT = 2;

  logic [4:0] sync_q;
  logic       bclk_s, bclk_q;
  logic       bclk_rise, bclk_fall;

  logic [NPORT-1:0]  p_ena, p_din, p_sdo, p_oe, p_valid, p_locked, p_wide, p_err, p_start, p_end;
  logic [WORD_W-1:0] p_txw [NPORT];
  logic [WORD_W-1:0] p_rxw [NPORT];

  // Named events for the checker.
  logic line_start, line_end, acou_start, acou_end;

  pcmif_sync #(.STAGES(SYNC_STAGES), .W(5)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({acou_sdi, acou_ena, line_sdi, line_ena, bclk}),
    .q(sync_q)
  );

  assign bclk_s   = sync_q[0];
  assign p_ena    = {sync_q[3], sync_q[1]};
  assign p_din    = {sync_q[4], sync_q[2]};
  assign p_txw[0] = line_tx_word;
  assign p_txw[1] = acou_tx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= bclk_s;
  end

  assign bclk_rise = bclk_s & ~bclk_q;
  assign bclk_fall = ~bclk_s & bclk_q;

  generate
    for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
      pcmif_port u_port (
        .clk(clk), .rst_n(rst_n),
        .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .ena_s(p_ena[gp]), .din_s(p_din[gp]), .tx_word(p_txw[gp]),
        .sdo(p_sdo[gp]), .sdo_oe(p_oe[gp]), .rx_word(p_rxw[gp]),
        .rx_valid(p_valid[gp]), .locked(p_locked[gp]), .wide(p_wide[gp]),
        .fmt_err(p_err[gp]), .strobe_start(p_start[gp]), .strobe_end(p_end[gp])
      );
    end
  endgenerate

  assign line_start = p_start[0];
  assign line_end   = p_end[0];
  assign acou_start = p_start[1];
  assign acou_end   = p_end[1];

  pcmif_window #(.WINDOW_CLKS(WINDOW_CLKS)) u_window (
    .clk(clk), .rst_n(rst_n),
    .frame_start(line_start), .second_start(acou_start),
    .timeout(window_timeout)
  );

  assign line_sdo      = p_sdo[0];
  assign line_sdo_oe   = p_oe[0];
  assign line_rx_word  = p_rxw[0];
  assign line_rx_valid = p_valid[0];
  assign line_locked   = p_locked[0];
  assign line_wide     = p_wide[0];
  assign line_fmt_err  = p_err[0];
  assign acou_sdo      = p_sdo[1];
  assign acou_sdo_oe   = p_oe[1];
  assign acou_rx_word  = p_rxw[1];
  assign acou_rx_valid = p_valid[1];
  assign acou_locked   = p_locked[1];
  assign acou_wide     = p_wide[1];
  assign acou_fmt_err  = p_err[1];
endmodule

// File: rtl/pcmif_ssi_chk.sv
module pcmif_ssi_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        line_rx_valid,
  input logic [15:0] line_rx_word,
  input logic        line_locked,
  input logic        line_wide,
  input logic        line_fmt_err,
  input logic        line_end,
  input logic        acou_rx_valid,
  input logic [15:0] acou_rx_word,
  input logic        acou_locked,
  input logic        acou_wide,
  input logic        acou_fmt_err,
  input logic        acou_end,
  input logic        acou_start,
  input logic        window_timeout
);
  AST_LINE_VALID_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) line_rx_valid |-> line_locked); // R3
  AST_ACOU_VALID_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) acou_rx_valid |-> acou_locked); // R3
  AST_LINE_VALID_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n) line_rx_valid |-> $past(line_end)); // R4
  AST_ACOU_VALID_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n) acou_rx_valid |-> $past(acou_end)); // R4
  AST_LINE_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) line_rx_valid |=> !line_rx_valid); // R4
  AST_LINE_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n) (line_rx_valid && !line_wide) |-> (line_rx_word[15:8] == 8'h00)); // R4
  AST_ACOU_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n) (acou_rx_valid && !acou_wide) |-> (acou_rx_word[15:8] == 8'h00)); // R4
  AST_LINE_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rst_n) line_locked |=> (line_locked && $stable(line_wide))); // R7
  AST_ACOU_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rst_n) acou_locked |=> (acou_locked && $stable(acou_wide))); // R7
  AST_LINE_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) $rose(line_fmt_err) |-> !line_rx_valid); // R7
  AST_TIMEOUT_NOT_ON_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n) (acou_start && !window_timeout) |=> !window_timeout); // R9
  AST_LINE_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) line_fmt_err |=> line_fmt_err); // R10
  AST_ACOU_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) acou_fmt_err |=> acou_fmt_err); // R10
  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) window_timeout |=> window_timeout); // R10
endmodule

bind pcmif_ssi pcmif_ssi_chk i_pcmif_ssi_chk (
  .clk(clk), .rst_n(rst_n),
  .line_rx_valid(line_rx_valid), .line_rx_word(line_rx_word),
  .line_locked(line_locked), .line_wide(line_wide),
  .line_fmt_err(line_fmt_err), .line_end(line_end),
  .acou_rx_valid(acou_rx_valid), .acou_rx_word(acou_rx_word),
  .acou_locked(acou_locked), .acou_wide(acou_wide),
  .acou_fmt_err(acou_fmt_err), .acou_end(acou_end),
  .acou_start(acou_start), .window_timeout(window_timeout)
);

// File: tb/test_pcmif_ssi.sv
`timescale 1ns/1ps
module test_pcmif_ssi;
  localparam int WIN = 2000;

  logic clk = 1'b0, bclk = 1'b0, rst_n = 1'b0;
  logic line_ena = 0, line_sdi = 0, acou_ena = 0, acou_sdi = 0;
  logic [15:0] line_tx_word = '0, acou_tx_word = '0;
  logic line_sdo, line_sdo_oe, line_rx_valid, line_locked, line_wide, line_fmt_err;
  logic acou_sdo, acou_sdo_oe, acou_rx_valid, acou_locked, acou_wide, acou_fmt_err;
  logic [15:0] line_rx_word, acou_rx_word;
  logic window_timeout;

  int checks = 0, errors = 0;
  int vcnt [2] = '{0, 0};
  logic [15:0] vlast [2];
  bit m_locked [2], m_wide [2];

  pcmif_ssi #(.SYNC_STAGES(2), .WINDOW_CLKS(WIN)) i_pcmif_ssi (.*);

  always #2.5 clk = ~clk;
  initial begin
    #1;
    forever #40 bclk = ~bclk;
  end

  always @(negedge clk) begin
    if (line_rx_valid) begin vcnt[0]++; vlast[0] = line_rx_word; end
    if (acou_rx_valid) begin vcnt[1]++; vlast[1] = acou_rx_word; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_locked = '{0, 0};
    m_wide = '{0, 0};
    repeat (6) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  // Idle bit periods; the output enable must stay low throughout (R2).
  task automatic idle(input int nbits, input int port);
    int bad = 0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge bclk);
      if ((port == 0 ? line_sdo_oe : acou_sdo_oe) !== 1'b0) bad++;
    end
    chk("R2 idle oe", bad, 0);
  endtask

  task automatic do_port(input int port, input int n, input logic [15:0] p, input logic [15:0] q);
    logic [15:0] cap = '0, exp16;
    int v0 = vcnt[port], bad = 0;
    bit w = (n == 16);
    bit acc = ((n == 8) || (n == 16)) && (!m_locked[port] || (m_wide[port] == w));
    exp16 = (m_locked[port] && m_wide[port]) ? q : {q[7:0], 8'h00};
    if (port == 0) line_tx_word = q; else acou_tx_word = q;
    for (int i = 0; i < n; i++) begin
      @(posedge bclk);
      if (port == 0) begin line_ena <= 1'b1; line_sdi <= p[n-1-i]; end
      else           begin acou_ena <= 1'b1; acou_sdi <= p[n-1-i]; end
      @(negedge bclk);
      cap = {cap[14:0], (port == 0) ? line_sdo : acou_sdo};
      if ((port == 0 ? line_sdo_oe : acou_sdo_oe) !== 1'b1) bad++;
    end
    @(posedge bclk);
    if (port == 0) begin line_ena <= 1'b0; line_sdi <= 1'b0; end
    else           begin acou_ena <= 1'b0; acou_sdi <= 1'b0; end
    chk("R2 strobe oe", bad, 0);
    chk("R5 tx serial", cap, exp16 >> (16 - n));
    idle(2, port);
    chk("R4 R7 R8 valid count", vcnt[port] - v0, acc ? 1 : 0);
    if (acc) begin
      chk("R4 rx word", vlast[port], w ? p : {8'h00, p[7:0]});
      if (!m_locked[port]) begin m_locked[port] = 1; m_wide[port] = w; end
    end
    chk("R3 locked", (port == 0) ? line_locked : acou_locked, m_locked[port]);
    chk("R3 R7 width", (port == 0) ? line_wide : acou_wide, m_wide[port]);
    if (!acc) chk("R7 R8 fmt err", (port == 0) ? line_fmt_err : acou_fmt_err, 1);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 oe", {line_sdo_oe, acou_sdo_oe}, 0);
    chk("R1 valid", {line_rx_valid, acou_rx_valid}, 0);
    chk("R1 lock", {line_locked, acou_locked}, 0);
    chk("R1 flags", {line_fmt_err, acou_fmt_err, window_timeout}, 0);

    // R6 mixed widths: line wide, acoustic narrow; walking-bit sweep
    for (int k = 0; k < 16; k++) begin
      do_port(0, 16, 16'hA5C3 ^ (16'h1 << k), 16'h3C96 ^ (16'h8000 >> k));
      do_port(1, 8, 16'h00FF & (16'h5A ^ (16'h1 << (k % 8))), 16'h00F0 ^ (16'h1 << (k % 8)));
    end
    chk("R6 widths", {line_wide, acou_wide}, 2'b10);
    chk("R9 no timeout", window_timeout, 0);
    chk("R7 R8 no err yet", {line_fmt_err, acou_fmt_err}, 0);

    // R7 wrong legal length on the narrow-locked acoustic port
    do_port(0, 16, 16'h1234, 16'hFEDC);
    do_port(1, 16, 16'hBEEF, 16'h00AA);
    chk("R7 line untouched", line_fmt_err, 0);

    // R9 missing acoustic strobe
    do_port(0, 16, 16'h0F0F, 16'h7777);
    idle(150, 1);
    chk("R9 timeout", window_timeout, 1);

    // R8 illegal length on line; R10 flags persist after good frames
    do_port(0, 12, 16'h0ABC, 16'h1111);
    do_port(0, 16, 16'hCAFE, 16'h8001);
    do_port(1, 8, 16'h0081, 16'h0042);
    chk("R10 sticky", {line_fmt_err, acou_fmt_err, window_timeout}, 3'b111);

    // Opposite locking; R8 illegal strobe before lock does not lock
    do_reset();
    do_port(0, 5, 16'h0015, 16'h00C5);
    chk("R8 not locked", line_locked, 0);
    for (int k = 0; k < 8; k++) begin
      do_port(0, 8, 16'h00FF & ~(16'h1 << k), 16'h0001 << k);
      do_port(1, 16, 16'hFFFF ^ (16'h3 << (2*k)), 16'hC001 ^ (16'h1 << (k+4)));
    end
    chk("R6 widths swapped", {line_wide, acou_wide}, 2'b01);
    chk("R9 no timeout after reset", window_timeout, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule